// File: doc/BRIEF.md
# CAN Bit Stuffing, Arbitration and CRC Unit

This block sits between the frame sequencer of a CAN node and the bit-timing logic. It works on one bit per bit-time strobe (`bit_stb`, a one-clock pulse at the sample point). On every strobe it samples the resolved bus level and launches the level the node drives for the following bit time. The bus is treated as wired-AND: dominant is 0 and wins over recessive 1.

On the transmit side the frame sequencer offers unstuffed bits on a valid/ready stream. The unit inserts a stuff bit of opposite polarity after every run of five equal bits. While arbitration is enabled, it compares each recessive bit it sent with the level it reads back, and backs off when it is overwritten. On the receive side it removes stuff bits and delivers the remaining bits. A sixth equal bit is reported as a stuff error. The 15-bit frame CRC is computed over the delivered bits of the stuffed region. An error flag of six dominant bits can be requested, and is raised by itself on a stuff error. The flag overrides any transmit data.

The enables `stuff_en` and `arb_en` given at a strobe describe the bit launched at that strobe. The unit delays them by one bit internally for the receive, arbitration and CRC side, because that bit is sampled at the next strobe. Transmit handshake: a bit is taken only in a cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is high only in strobe cycles. When no bit is offered at a launch, recessive is sent. The receive stream has no ready, because the bus cannot be held back. `rx_valid` is a one-clock pulse, and the consumer must take the bit in that cycle.

Top module: `can_bitstream_unit`

## Requirements
- R1: After reset `bus_tx` is recessive (1), `tx_ready`, `rx_valid`, `stuff_err` and `arb_lost` are 0 and `crc` is 0.
- R2: A transmission starts only at a strobe after IDLE_BITS (11) consecutive recessive bus samples. After reset with `tx_active` high, the first `tx_ready` comes at the 12th strobe.
- R3: While `stuff_en` is high, after five launched bits of equal value the next launch is a bit of opposite value and takes no data (`tx_ready` low). That inserted bit counts as the first bit of the next run.
- R4: With `stuff_en` low no stuff bit is inserted: every strobe of an active transmission takes a data bit, even after long runs.
- R5: When arbitration was enabled for the bit on the bus and the unit sent recessive but samples dominant, `arb_lost` pulses for one clock after that strobe. `tx_ready` is low at that strobe, `bus_tx` becomes recessive, and no further data is taken until the bus is idle again.
- R6: With arbitration disabled, a dominant sample over a sent recessive bit is ignored: no `arb_lost`, and transmission continues.
- R7: The receive side, over the stuffed region, drops the bit that follows five equal bits. Every other sampled bit is delivered as `rx_bit` with a `rx_valid` pulse one clock after its strobe. Five equal bits alone give no error.
- R8: A sixth equal bit in the stuffed region pulses `stuff_err` one clock after its strobe and starts an error flag.
- R9: An error flag (from `err_req` at a strobe, or from R8) drives exactly six dominant bits from that strobe on and then recessive. It overrides transmit data, and `tx_ready` stays low during it.
- R10: `crc` uses the polynomial x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 (0x4599). It starts at zero with the first bit of the stuffed region, is updated only on delivered (destuffed) bits, and holds after the region ends. When the data is followed by its own CRC, MSB first, the result is zero.
- R11: `tx_ready` is never high outside a strobe cycle or while `tx_active` is low. A launch with `tx_valid` low sends recessive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One-clock pulse per bit time, at the sample point |
| stuff_en | input | 1 | Bit launched at this strobe lies in the stuffed region |
| arb_en | input | 1 | Bit launched at this strobe lies in the arbitration region |
| tx_active | input | 1 | Frame sequencer wants to transmit |
| tx_valid | input | 1 | Transmit bit offered |
| tx_bit | input | 1 | Transmit bit value |
| tx_ready | output | 1 | Transmit bit taken this cycle (strobe cycles only) |
| err_req | input | 1 | Request an error flag at this strobe |
| bus_rx | input | 1 | Resolved bus level |
| bus_tx | output | 1 | Level driven onto the bus (0 dominant) |
| rx_valid | output | 1 | Destuffed receive bit present |
| rx_bit | output | 1 | Destuffed receive bit value |
| stuff_err | output | 1 | Stuff error pulse |
| arb_lost | output | 1 | Arbitration lost pulse |
| crc | output | 15 | CRC over destuffed bits of the stuffed region |

## Verification
The assertions assume that `bit_stb` is a single-clock pulse with idle clocks between pulses. They also assume that `err_req` is only raised while no error flag is on the bus, and that `bus_rx` is the wired-AND of `bus_tx` with the other nodes. The bench builds `bus_rx` exactly that way from one modelled second node. It spaces strobes two clocks apart, and issues `err_req` only on a quiet bus. Every frame is preceded by a full idle period, so the delayed region enables always start from a clean state.

// File: rtl/can_bs_pkg.sv
package can_bs_pkg;
  localparam int CRC_W = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;

  // One serial CRC step, MSB-first feedback.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    crc_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/can_tx_stuffer.sv
module can_tx_stuffer #(
  parameter int RUN_LEN  = 5,
  parameter int FLAG_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic stuff_en,
  input  logic arb_chk,
  input  logic tx_active,
  input  logic bus_idle,
  input  logic bus_rx,
  input  logic tx_valid,
  input  logic tx_bit,
  input  logic flag_go,
  output logic tx_ready,
  output logic bus_tx,
  output logic arb_lost,
  output logic flag_busy
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam int FW = $clog2(FLAG_LEN + 1);

  logic [RW-1:0] run;
  logic          last;
  logic          xmit_q;
  logic [FW-1:0] flag_cnt;
  logic          drv_q;
  logic          lose, can_send, need_stuff, next_bit;

  assign flag_busy  = (flag_cnt != '0);
  assign lose       = xmit_q && arb_chk && drv_q && !bus_rx && !flag_busy;
  assign can_send   = tx_active && (xmit_q || bus_idle) && !lose && !flag_busy && !flag_go;
  assign need_stuff = stuff_en && (run == RW'(RUN_LEN));
  assign tx_ready   = bit_stb && can_send && !need_stuff;
  assign next_bit   = tx_valid ? tx_bit : 1'b1;
  assign bus_tx     = drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q    <= 1'b1;
      run      <= '0;
      last     <= 1'b1;
      xmit_q   <= 1'b0;
      flag_cnt <= '0;
      arb_lost <= 1'b0;
    end else begin
      arb_lost <= 1'b0;
      if (bit_stb) begin
        if (flag_go && !flag_busy) begin
          flag_cnt <= FW'(FLAG_LEN);
          drv_q    <= 1'b0;
          xmit_q   <= 1'b0;
          run      <= '0;
        end else if (flag_busy) begin
          flag_cnt <= flag_cnt - 1'b1;
          drv_q    <= (flag_cnt == FW'(1));
        end else if (lose) begin
          arb_lost <= 1'b1;
          xmit_q   <= 1'b0;
          drv_q    <= 1'b1;
          run      <= '0;
        end else if (can_send) begin
          xmit_q <= 1'b1;
          if (need_stuff) begin
            drv_q <= ~last;
            last  <= ~last;
            run   <= RW'(1);
          end else begin
            drv_q <= next_bit;
            last  <= next_bit;
            if (!stuff_en)
              run <= '0;
            else if (run != '0 && next_bit == last)
              run <= run + 1'b1;
            else
              run <= RW'(1);
          end
        end else begin
          xmit_q <= 1'b0;
          drv_q  <= 1'b1;
          run    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/can_rx_destuffer.sv
module can_rx_destuffer #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic region,
  input  logic hold,
  input  logic bus_rx,
  output logic viol,
  output logic take,
  output logic rx_valid,
  output logic rx_bit,
  output logic stuff_err
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] run;
  logic          last;
  logic          at_limit;

  assign at_limit = region && (run == RW'(RUN_LEN));
  assign viol     = bit_stb && at_limit && (bus_rx == last) && !hold;
  assign take     = bit_stb && !at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= '0;
      last      <= 1'b1;
      rx_valid  <= 1'b0;
      rx_bit    <= 1'b1;
      stuff_err <= 1'b0;
    end else begin
      rx_valid  <= take;
      stuff_err <= viol;
      if (take) rx_bit <= bus_rx;
      if (bit_stb) begin
        if (!region || hold) begin
          run <= '0;
        end else if (at_limit) begin
          if (viol) begin
            run <= '0;
          end else begin
            run  <= RW'(1);
            last <= bus_rx;
          end
        end else begin
          last <= bus_rx;
          if (run != '0 && bus_rx == last) run <= run + 1'b1;
          else                             run <= RW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/can_crc15.sv
module can_crc15
  import can_bs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '0;
    else if (en)    crc <= crc_step(start ? '0 : crc, din);
    else if (start) crc <= '0;
  end
endmodule

// File: rtl/can_bitstream_unit.sv
module can_bitstream_unit
  import can_bs_pkg::*;
#(
  parameter int RUN_LEN   = 5,
  parameter int FLAG_LEN  = 6,
  parameter int IDLE_BITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             stuff_en,
  input  logic             arb_en,
  input  logic             tx_active,
  input  logic             tx_valid,
  input  logic             tx_bit,
  output logic             tx_ready,
  input  logic             err_req,
  input  logic             bus_rx,
  output logic             bus_tx,
  output logic             rx_valid,
  output logic             rx_bit,
  output logic             stuff_err,
  output logic             arb_lost,
  output logic [CRC_W-1:0] crc
);
  localparam int IW = $clog2(IDLE_BITS + 1);

  logic          stuff_q, stuff_qq, arb_q;
  logic [IW-1:0] idle_cnt;
  logic          bus_idle, flag_busy, viol, take;

  // Region enables refer to the launched bit; the sampled bit is one behind.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stuff_q  <= 1'b0;
      stuff_qq <= 1'b0;
      arb_q    <= 1'b0;
      idle_cnt <= '0;
    end else if (bit_stb) begin
      stuff_q  <= stuff_en;
      stuff_qq <= stuff_q;
      arb_q    <= arb_en;
      if (!bus_rx)                          idle_cnt <= '0;
      else if (idle_cnt != IW'(IDLE_BITS))  idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign bus_idle = (idle_cnt == IW'(IDLE_BITS));

  can_tx_stuffer #(.RUN_LEN(RUN_LEN), .FLAG_LEN(FLAG_LEN)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .stuff_en  (stuff_en),
    .arb_chk   (arb_q),
    .tx_active (tx_active),
    .bus_idle  (bus_idle),
    .bus_rx    (bus_rx),
    .tx_valid  (tx_valid),
    .tx_bit    (tx_bit),
    .flag_go   (err_req || viol),
    .tx_ready  (tx_ready),
    .bus_tx    (bus_tx),
    .arb_lost  (arb_lost),
    .flag_busy (flag_busy)
  );

  can_rx_destuffer #(.RUN_LEN(RUN_LEN)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .region    (stuff_q),
    .hold      (flag_busy),
    .bus_rx    (bus_rx),
    .viol      (viol),
    .take      (take),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .stuff_err (stuff_err)
  );

  can_crc15 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (bit_stb && stuff_q && !stuff_qq),
    .en    (take && stuff_q),
    .din   (bus_rx),
    .crc   (crc)
  );
endmodule

// File: rtl/can_bitstream_chk.sv
module can_bitstream_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_stb,
  input logic        stuff_en,
  input logic        arb_en,
  input logic        tx_active,
  input logic        tx_valid,
  input logic        tx_bit,
  input logic        tx_ready,
  input logic        err_req,
  input logic        bus_rx,
  input logic        bus_tx,
  input logic        rx_valid,
  input logic        rx_bit,
  input logic        stuff_err,
  input logic        arb_lost,
  input logic [14:0] crc
);
  a_r11_ready_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> bit_stb);

  a_r11_no_ready_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !tx_ready);

  a_r5_lost_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> bus_tx);

  a_r5_lost_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> $past(bit_stb && !bus_rx));

  a_r7_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bit_stb));

  a_r8_error_starts_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> (!bus_tx && $past(bit_stb)));

  a_r9_flag_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && err_req && bus_tx) |=> !bus_tx);

  a_r9_no_ready_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && err_req) |-> !tx_ready);
endmodule

bind can_bitstream_unit can_bitstream_chk u_chk (.*);

// File: tb/tb_can_bitstream_unit.sv
module tb_can_bitstream_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, bit_stb = 1'b0, stuff_en = 1'b0, arb_en = 1'b0;
  logic tx_active = 1'b0, tx_valid = 1'b0, tx_bit = 1'b1, err_req = 1'b0;
  logic other_bit = 1'b1;
  logic bus_rx, bus_tx, tx_ready, rx_valid, rx_bit, stuff_err, arb_lost;
  logic [14:0] crc;

  assign bus_rx = bus_tx & other_bit;

  can_bitstream_unit dut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .stuff_en(stuff_en), .arb_en(arb_en),
    .tx_active(tx_active), .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
    .err_req(err_req), .bus_rx(bus_rx), .bus_tx(bus_tx), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .stuff_err(stuff_err), .arb_lost(arb_lost), .crc(crc)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam int NV = 5;
  localparam logic [15:0] TV_DATA  [NV] = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'hF800, 16'h07C1};
  localparam int          TV_STUFF [NV] = '{3, 3, 0, 3, 3};

  bit dbuf [0:63];  int dn;
  bit sbuf [0:95];  int sn;
  bit txcap[0:95];  int tn;
  bit rxcap[0:63];  int rn;
  logic s_ready, s_rxv, s_rxb, s_serr, s_lost;
  bit any_serr;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    bit_stb = 1'b1;
    #1 s_ready = tx_ready;
    @(posedge clk);
    #1 bit_stb = 1'b0;
    @(negedge clk);
    s_rxv  = rx_valid;
    s_rxb  = rx_bit;
    s_serr = stuff_err;
    s_lost = arb_lost;
  endtask

  task automatic go_idle();
    tx_active = 1'b0; stuff_en = 1'b0; arb_en = 1'b0; tx_valid = 1'b0;
    err_req = 1'b0; other_bit = 1'b1;
    repeat (12) strobe();
  endtask

  task automatic stuff_ref();
    int run = 0;
    bit last = 1'b1;
    sn = 0;
    for (int i = 0; i < dn; i++) begin
      if (run == 5) begin
        last = ~last; sbuf[sn] = last; sn++; run = 1;
      end
      sbuf[sn] = dbuf[i]; sn++;
      if (run != 0 && dbuf[i] == last) run++;
      else run = 1;
      last = dbuf[i];
    end
  endtask

  function automatic logic [14:0] crc_ref(input int n);
    logic [14:0] c = '0;
    for (int i = 0; i < n; i++) begin
      logic fb;
      fb = c[14] ^ dbuf[i];
      c = {c[13:0], 1'b0};
      if (fb) c = c ^ 15'h4599;
    end
    return c;
  endfunction

  task automatic send_frame();
    int p = 0;
    int guard = 0;
    bit first = 1'b1;
    tn = 0; rn = 0; any_serr = 1'b0;
    stuff_en = 1'b1; tx_active = 1'b1; tx_valid = 1'b1;
    while (p < dn && guard < 200) begin
      tx_bit = dbuf[p];
      strobe();
      if (!first && s_rxv) begin rxcap[rn] = s_rxb; rn++; end
      first = 1'b0;
      if (s_ready) p++;
      txcap[tn] = bus_tx; tn++;
      any_serr |= s_serr;
      guard++;
    end
    stuff_en = 1'b0; tx_active = 1'b0; tx_valid = 1'b0;
    strobe();
    if (s_rxv) begin rxcap[rn] = s_rxb; rn++; end
    any_serr |= s_serr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt, mism, first_rdy, zeros;
    logic [14:0] cexp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(bus_tx == 1'b1, "R1 bus_tx", bus_tx, 1);
    check(tx_ready == 1'b0 && rx_valid == 1'b0, "R1 ready/valid", {tx_ready, rx_valid}, 0);
    check(stuff_err == 1'b0 && arb_lost == 1'b0, "R1 err/lost", {stuff_err, arb_lost}, 0);
    check(crc == 15'd0, "R1 crc", crc, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 idle detection before first launch
    tx_active = 1'b1; tx_valid = 1'b1; tx_bit = 1'b0;
    first_rdy = 0;
    for (int k = 1; k <= 20; k++) begin
      strobe();
      if (s_ready && first_rdy == 0) first_rdy = k;
    end
    check(first_rdy == 12, "R2 first ready strobe", first_rdy, 12);

    // R3 / R7 / R10 table of transmit frames, received back from the bus
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 16; i++) dbuf[i] = TV_DATA[v][15 - i];
      dn = 16;
      stuff_ref();
      go_idle();
      send_frame();
      check(tn - dn == TV_STUFF[v], "R3 stuff count", tn - dn, TV_STUFF[v]);
      mism = (tn != sn) ? 1 : 0;
      for (int i = 0; i < tn && i < sn; i++) if (txcap[i] != sbuf[i]) mism++;
      check(mism == 0, "R3 stuffed stream", mism, 0);
      mism = (rn != dn) ? 1 : 0;
      for (int i = 0; i < rn && i < dn; i++) if (rxcap[i] != dbuf[i]) mism++;
      check(mism == 0, "R7 destuffed bits", rn, dn);
      cexp = crc_ref(dn);
      check(crc == cexp, "R10 crc value", crc, cexp);
      check(any_serr == 1'b0, "R8 no false stuff error", any_serr, 0);
    end

    // R10 data followed by its own CRC leaves zero
    cexp = crc_ref(16);
    for (int i = 0; i < 15; i++) dbuf[16 + i] = cexp[14 - i];
    dn = 31;
    go_idle();
    send_frame();
    check(rn == 31, "R10 residue bit count", rn, 31);
    check(crc == 15'd0, "R10 zero residue", crc, 0);

    // R7 / R8 / R9 stuff error from another node, then error flag
    go_idle();
    stuff_en = 1'b1; other_bit = 1'b1;
    strobe();
    zeros = 0;
    for (int k = 1; k <= 6; k++) begin
      other_bit = 1'b0;
      if (k == 6) stuff_en = 1'b0;
      strobe();
      if (k < 6) check(s_serr == 1'b0, "R7 five equal no error", s_serr, 0);
      else       check(s_serr == 1'b1, "R8 sixth equal error", s_serr, 1);
    end
    if (bus_tx == 1'b0) zeros++;
    other_bit = 1'b1;
    for (int k = 0; k < 5; k++) begin
      strobe();
      if (bus_tx == 1'b0) zeros++;
    end
    check(zeros == 6, "R9 flag length", zeros, 6);
    strobe();
    check(bus_tx == 1'b1, "R9 flag release", bus_tx, 1);

    // R9 requested flag overrides transmit data
    go_idle();
    tx_active = 1'b1; tx_valid = 1'b1; tx_bit = 1'b1;
    strobe(); strobe();
    err_req = 1'b1;
    strobe();
    err_req = 1'b0;
    check(s_ready == 1'b0 && bus_tx == 1'b0, "R9 flag start", {s_ready, bus_tx}, 0);
    cnt = 0; zeros = 0;
    for (int k = 0; k < 5; k++) begin
      strobe();
      if (s_ready) cnt++;
      if (bus_tx == 1'b0) zeros++;
    end
    check(zeros == 5 && cnt == 0, "R9 flag body", zeros, 5);
    strobe();
    check(bus_tx == 1'b1, "R9 flag end", bus_tx, 1);

    // R5 arbitration lost on a recessive bit
    for (int i = 0; i < 16; i++) dbuf[i] = TV_DATA[2][15 - i];
    go_idle();
    tx_active = 1'b1; tx_valid = 1'b1; arb_en = 1'b1;
    for (int i = 0; i < 3; i++) begin tx_bit = dbuf[i]; strobe(); end
    other_bit = 1'b0; tx_bit = dbuf[3];
    strobe();
    check(s_lost == 1'b1, "R5 arb_lost pulse", s_lost, 1);
    check(s_ready == 1'b0 && bus_tx == 1'b1, "R5 release", {s_ready, bus_tx}, 1);
    other_bit = 1'b1; cnt = 0;
    for (int k = 0; k < 3; k++) begin
      strobe();
      if (s_ready || !bus_tx) cnt++;
    end
    check(cnt == 0, "R5 stays off bus", cnt, 0);

    // R6 same mismatch outside the arbitration region
    go_idle();
    tx_active = 1'b1; tx_valid = 1'b1; arb_en = 1'b0;
    for (int i = 0; i < 3; i++) begin tx_bit = dbuf[i]; strobe(); end
    other_bit = 1'b0; tx_bit = dbuf[3];
    strobe();
    check(s_lost == 1'b0 && s_ready == 1'b1, "R6 mismatch ignored", {s_lost, s_ready}, 1);
    other_bit = 1'b1;

    // R4 no stuffing outside the stuffed region
    go_idle();
    tx_active = 1'b1; tx_valid = 1'b1; tx_bit = 1'b0;
    cnt = 0; zeros = 0;
    for (int k = 0; k < 8; k++) begin
      strobe();
      if (s_ready) cnt++;
      if (bus_tx == 1'b0) zeros++;
    end
    check(cnt == 8 && zeros == 8, "R4 no insert", cnt, 8);

    // R11 underrun and strobe-only ready
    tx_valid = 1'b0;
    strobe();
    check(s_ready == 1'b1 && bus_tx == 1'b1, "R11 underrun recessive", {s_ready, bus_tx}, 3);
    @(negedge clk);
    check(tx_ready == 1'b0, "R11 ready off strobe", tx_ready, 0);
    tx_active = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule